// File: doc/BRIEF.md
# Security Identifier Program and Lock Engine

This block is the device-side handler inside a serial quad-I/O memory for two commands: one that writes bytes into a 32-byte security identifier, and one that locks that identifier for good. While chip-select is low, the host sends one nibble on `nib` on each cycle in which `nib_vld` is high. Two nibbles make one byte, and the first nibble is the upper half. The first byte of a frame is the command code.

A program frame has three parts: the code 0xA5, one start address, and then the data bytes. The engine checks three things before it accepts the frame. The write-enable latch must be set. The address must lie in the user region. The identifier must not be locked. Each accepted byte is stored at once, and the address then moves up by one.

When chip-select rises after a valid program frame or a lockout frame (code 0x85 alone), a self-timed busy interval starts. At the end of that interval the write-enable latch clears, and a pending lockout takes effect. The lower part of the identifier is preset at reset with a fixed factory pattern. A read port exposes the array contents.

Top module: `sid_prog_top`

## Requirements
- R1: The two nibbles of a byte form {first, second}: the nibble received first is bits 7:4.
- R2: A frame with 0xA5, a start address A and data bytes stores the k-th data byte at A+k. The frame must start with the write-enable latch set, the array unlocked and the engine not busy.
- R3: A program frame whose address is below FACTORY_TOP (0x08) or at ID_BYTES (0x20) or above is ignored. It writes nothing, starts no busy interval and leaves the write-enable latch unchanged.
- R4: A one-cycle pulse on `wen_set` sets `wel` when the engine is not busy. A program frame sent with `wel` clear is ignored.
- R5: If chip-select rises after an odd number of data nibbles, the unpaired last nibble is discarded. The whole bytes before it are still written.
- R6: After a frame that is accepted, `busy` goes high in the cycle after chip-select is sampled high. It stays high for exactly BUSY_CYCLES cycles (20 by default), and `wel` clears in the same cycle that `busy` falls. An accepted frame is a program frame with at least one stored byte, or a lockout frame.
- R7: A frame that holds only 0x85 sets `locked` when its busy interval ends. `locked` never clears, and later program frames change nothing. A 0x85 frame that carries any further byte is ignored.
- R8: A program frame stores at most MAX_DATA (24) bytes. Bytes that would land above address 0x1F are dropped and do not wrap to the start of the array.
- R9: A frame whose command byte arrives while `busy` is high is ignored. So is a frame with any code other than 0xA5 or 0x85. Neither kind starts a busy interval.
- R10: After reset, `busy` and `wel` are 0 and `locked` equals LOCK_INIT. Byte i holds 0xC0+i for i < FACTORY_TOP, and every other byte holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low; its rising edge ends a frame |
| nib_vld | input | 1 | Qualifies `nib` as one serial-clock nibble |
| nib | input | 4 | Nibble from the four data lines |
| wen_set | input | 1 | Pulse that sets the write-enable latch |
| rd_addr | input | 5 | Identifier byte to observe |
| rd_data | output | 8 | Contents of the addressed byte |
| busy | output | 1 | Self-timed operation in progress |
| wel | output | 1 | Write-enable latch |
| locked | output | 1 | Identifier permanently locked |

## Verification
A wrong frame state, for example an address accepted when it should have been rejected, shows up on the read port two cycles after the second nibble of the byte concerned. It also shows up as a busy pulse one cycle after chip-select rises when no pulse was due. A miscounted busy timer makes the busy interval the wrong length, and it moves the fall of `wel` and the rise of `locked` to the wrong cycle; both are visible as soon as the interval ends. A bad pointer or byte counter shows up in the full-array readback that follows each frame. Typical causes are dropped bytes, a write that wraps to the start of the array, or more than 24 bytes written.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam logic [7:0] CMD_PROG = 8'hA5;
    localparam logic [7:0] CMD_LOCK = 8'h85;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_LOCK,
        ST_SKIP
    } sid_st_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } sid_wr_t;

    function automatic logic [7:0] fac_byte(input int idx);
        return 8'hC0 + 8'(idx);
    endfunction

endpackage

// File: rtl/sid_nib_asm.sv
module sid_nib_asm (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       nib_vld,
    input  logic [3:0] nib,
    output logic       byte_vld,
    output logic [7:0] byte_val
);
    logic       have_hi;
    logic [3:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_hi  <= 1'b0;
            hi_q     <= '0;
            byte_vld <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (nib_vld) begin
                if (!have_hi) begin
                    have_hi <= 1'b1;
                    hi_q    <= nib;
                end else begin
                    have_hi  <= 1'b0;
                    byte_vld <= 1'b1;
                    byte_val <= {hi_q, nib};
                end
            end
        end
    end
endmodule

// File: rtl/sid_busy_tmr.sv
module sid_busy_tmr #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/sid_id_store.sv
module sid_id_store
    import sid_pkg::*;
#(
    parameter int ID_BYTES    = 32,
    parameter int FACTORY_TOP = 8,
    localparam int AW         = $clog2(ID_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  sid_wr_t       wr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [ID_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ID_BYTES; i++) begin
                mem[i] <= (i < FACTORY_TOP) ? fac_byte(i) : 8'hFF;
            end
        end else if (wr.en) begin
            mem[wr.addr[AW-1:0]] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sid_prog_top.sv
module sid_prog_top
    import sid_pkg::*;
#(
    parameter int   ID_BYTES    = 32,
    parameter int   FACTORY_TOP = 8,
    parameter int   MAX_DATA    = 24,
    parameter int   BUSY_CYCLES = 20,
    parameter logic LOCK_INIT   = 1'b0,
    localparam int  AW          = $clog2(ID_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          nib_vld,
    input  logic [3:0]    nib,
    input  logic          wen_set,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          wel,
    output logic          locked
);
    logic       byte_vld;
    logic [7:0] byte_val;
    logic       cs_q, cs_rise;
    sid_st_e    st, nx_st;
    logic [7:0] ptr, nx_ptr, cnt, nx_cnt;
    sid_wr_t    wr_req;
    logic       go_prog, go_lock, tmr_done, lock_pend;

    sid_nib_asm u_asm (
        .clk(clk), .rst(rst), .clr(cs_n), .nib_vld(nib_vld), .nib(nib),
        .byte_vld(byte_vld), .byte_val(byte_val)
    );

    sid_busy_tmr #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(go_prog || go_lock),
        .busy(busy), .done(tmr_done)
    );

    sid_id_store #(.ID_BYTES(ID_BYTES), .FACTORY_TOP(FACTORY_TOP)) u_store (
        .clk(clk), .rst(rst), .wr(wr_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign cs_rise = cs_n && !cs_q;

    // Frame decode: a byte that completes in the same cycle as the
    // chip-select rise is still decoded before the frame is judged.
    always_comb begin
        nx_st  = st;
        nx_ptr = ptr;
        nx_cnt = cnt;
        wr_req = '0;
        if (byte_vld) begin
            unique case (st)
                ST_CMD: begin
                    if (busy)                       nx_st = ST_SKIP;
                    else if (byte_val == CMD_PROG)  nx_st = ST_ADDR;
                    else if (byte_val == CMD_LOCK)  nx_st = ST_LOCK;
                    else                            nx_st = ST_SKIP;
                end
                ST_ADDR: begin
                    if (int'(byte_val) >= FACTORY_TOP && int'(byte_val) < ID_BYTES
                        && wel && !locked) begin
                        nx_st  = ST_DATA;
                        nx_ptr = byte_val;
                        nx_cnt = '0;
                    end else begin
                        nx_st = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    if (int'(cnt) < MAX_DATA && int'(ptr) < ID_BYTES) begin
                        wr_req.en   = 1'b1;
                        wr_req.addr = ptr;
                        wr_req.data = byte_val;
                        nx_ptr      = ptr + 8'd1;
                        nx_cnt      = cnt + 8'd1;
                    end
                end
                ST_LOCK: nx_st = ST_SKIP;
                default: nx_st = ST_SKIP;
            endcase
        end
    end

    assign go_prog = cs_rise && (nx_st == ST_DATA) && (nx_cnt != '0);
    assign go_lock = cs_rise && (nx_st == ST_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b1;
            st        <= ST_CMD;
            ptr       <= '0;
            cnt       <= '0;
            wel       <= 1'b0;
            locked    <= LOCK_INIT;
            lock_pend <= 1'b0;
        end else begin
            cs_q <= cs_n;
            st   <= cs_n ? ST_CMD : nx_st;
            ptr  <= nx_ptr;
            cnt  <= nx_cnt;
            if (tmr_done)              wel <= 1'b0;
            else if (wen_set && !busy) wel <= 1'b1;
            if (go_lock)               lock_pend <= 1'b1;
            else if (tmr_done)         lock_pend <= 1'b0;
            if (tmr_done && lock_pend) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/sid_prog_chk.sv
module sid_prog_chk #(
    parameter int ID_BYTES    = 32,
    parameter int FACTORY_TOP = 8,
    parameter int MAX_DATA    = 24,
    parameter int BUSY_CYCLES = 20
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       busy,
    input logic       wel,
    input logic       locked,
    input logic       wr_en,
    input logic [7:0] wr_addr
);
    int run;
    int fcount;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 0;
            fcount <= 0;
        end else begin
            run <= busy ? run + 1 : 0;
            if (cs_n)       fcount <= 0;
            else if (wr_en) fcount <= fcount + 1;
        end
    end

    a_r6_busy_after_ce: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

    a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == BUSY_CYCLES));

    a_r6_wel_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> $fell(busy));

    a_r4_wel_set_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy));

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r3_user_region: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) >= FACTORY_TOP && int'(wr_addr) < ID_BYTES));

    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wel && !locked));

    a_r8_max_bytes: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (fcount < MAX_DATA));

    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_en);
endmodule

bind sid_prog_top sid_prog_chk #(
    .ID_BYTES(ID_BYTES), .FACTORY_TOP(FACTORY_TOP),
    .MAX_DATA(MAX_DATA), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .busy(busy), .wel(wel),
    .locked(locked), .wr_en(wr_req.en), .wr_addr(wr_req.addr)
);

// File: tb/sim_sid_prog_top.sv
`timescale 1ns/1ps
module sim_sid_prog_top;
    localparam int BC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       nib_vld = 1'b0;
    logic [3:0] nib = '0;
    logic       wen_set = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd0, rd1;
    logic       busy0, wel0, locked0, busy1, wel1, locked1;

    int total = 0;
    int bad = 0;
    string cur_req = "R10";

    typedef struct packed {
        logic       inst;
        logic [4:0] a;
        logic [7:0] d;
    } sb_t;
    sb_t sbq[$];
    logic [7:0] m0 [32];
    logic [7:0] m1 [32];
    logic [7:0] fb[$];

    always #2 clk = ~clk;

    sid_prog_top #(.BUSY_CYCLES(BC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .nib_vld(nib_vld), .nib(nib),
        .wen_set(wen_set), .rd_addr(rd_addr), .rd_data(rd0),
        .busy(busy0), .wel(wel0), .locked(locked0)
    );

    sid_prog_top #(.BUSY_CYCLES(BC), .LOCK_INIT(1'b1)) u1 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .nib_vld(nib_vld), .nib(nib),
        .wen_set(wen_set), .rd_addr(rd_addr), .rd_data(rd1),
        .busy(busy1), .wel(wel1), .locked(locked1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected array bytes and compares at the read port.
    initial begin
        forever begin
            sb_t it;
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            @(negedge clk);
            rd_addr = it.a;
            #1;
            check($sformatf("%s addr %0h", cur_req, it.a),
                  it.inst ? rd1 : rd0, it.d);
        end
    end

    task automatic sweep(input string req, input logic inst);
        cur_req = req;
        for (int i = 0; i < 32; i++) begin
            sbq.push_back({inst, 5'(i), inst ? m1[i] : m0[i]});
        end
        wait (sbq.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic wen();
        @(negedge clk) wen_set = 1'b1;
        @(negedge clk) wen_set = 1'b0;
    endtask

    task automatic send_frame(input bit odd, input logic [3:0] on);
        @(negedge clk) cs_n = 1'b0;
        foreach (fb[i]) begin
            @(negedge clk) begin nib_vld = 1'b1; nib = fb[i][7:4]; end
            @(negedge clk) nib = fb[i][3:0];
        end
        if (odd) @(negedge clk) nib = on;
        @(negedge clk) begin nib_vld = 1'b0; cs_n = 1'b1; end
    endtask

    task automatic expect_busy(input string req, input bit lock_now);
        int n = 0;
        @(negedge clk);
        check({req, " busy start"}, busy0, 1'b1);
        check({req, " wel held during busy"}, wel0, 1'b1);
        if (lock_now) check({req, " not locked during busy"}, locked0, 1'b0);
        while (busy0) begin
            n++;
            @(negedge clk);
        end
        check({req, " busy length"}, n, BC);
        check({req, " wel cleared"}, wel0, 1'b0);
    endtask

    task automatic expect_idle(input string req);
        repeat (2) begin
            @(negedge clk);
            check({req, " no busy"}, busy0, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m0[i] = (i < 8) ? 8'hC0 + 8'(i) : 8'hFF;
            m1[i] = m0[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", busy0, 1'b0);
        check("R10 wel", wel0, 1'b0);
        check("R10 locked", locked0, 1'b0);
        check("R10 locked init", locked1, 1'b1);
        sweep("R10", 1'b0);
        sweep("R10", 1'b1);

        // R4: no write-enable, program ignored
        fb = '{8'hA5, 8'h10, 8'hAA};
        send_frame(0, 0);
        expect_idle("R4");
        sweep("R4", 1'b0);

        // R1 R2 R6: normal program
        wen();
        check("R4 wel set", wel0, 1'b1);
        fb = '{8'hA5, 8'h08, 8'h12, 8'h34, 8'h56};
        send_frame(0, 0);
        m0[8] = 8'h12; m0[9] = 8'h34; m0[10] = 8'h56;
        expect_busy("R6", 0);
        sweep("R1 R2", 1'b0);
        sweep("R7 locked copy", 1'b1);

        // R3: factory and out-of-range addresses
        wen();
        fb = '{8'hA5, 8'h04, 8'h99};
        send_frame(0, 0);
        expect_idle("R3 factory");
        check("R3 wel kept", wel0, 1'b1);
        fb = '{8'hA5, 8'h20, 8'h99};
        send_frame(0, 0);
        expect_idle("R3 range");
        check("R3 wel kept", wel0, 1'b1);
        sweep("R3", 1'b0);

        // R8: no wrap past the top address
        fb = '{8'hA5, 8'h1E, 8'h01, 8'h02, 8'h03};
        send_frame(0, 0);
        m0[30] = 8'h01; m0[31] = 8'h02;
        expect_busy("R8 top", 0);
        sweep("R8 top", 1'b0);

        // R8: at most 24 bytes
        wen();
        fb = '{8'hA5, 8'h08};
        for (int k = 0; k < 26; k++) fb.push_back(8'h40 + 8'(k));
        send_frame(0, 0);
        for (int k = 0; k < 24; k++) m0[8 + k] = 8'h40 + 8'(k);
        expect_busy("R8 max", 0);
        sweep("R8 max", 1'b0);

        // R5: trailing odd nibble discarded
        wen();
        fb = '{8'hA5, 8'h0C, 8'h9A};
        send_frame(1, 4'h7);
        m0[12] = 8'h9A;
        expect_busy("R5", 0);
        sweep("R5", 1'b0);

        // R9: command while busy is ignored
        wen();
        fb = '{8'hA5, 8'h10, 8'h11};
        send_frame(0, 0);
        m0[16] = 8'h11;
        fb = '{8'hA5, 8'h11, 8'h22};
        send_frame(0, 0);
        check("R9 still busy", busy0, 1'b1);
        wait (!busy0);
        @(negedge clk);
        check("R9 wel after busy", wel0, 1'b0);
        expect_idle("R9 no second busy");
        sweep("R9 busy", 1'b0);

        // R9: unknown code
        wen();
        fb = '{8'h03, 8'h08, 8'h77};
        send_frame(0, 0);
        expect_idle("R9 unknown");
        check("R9 wel kept", wel0, 1'b1);
        sweep("R9 unknown", 1'b0);

        // R7: lockout with extra byte ignored, then real lockout
        fb = '{8'h85, 8'h00};
        send_frame(0, 0);
        expect_idle("R7 extra byte");
        check("R7 not locked", locked0, 1'b0);
        fb = '{8'h85};
        send_frame(0, 0);
        expect_busy("R7 lockout", 1);
        check("R7 locked", locked0, 1'b1);
        wen();
        fb = '{8'hA5, 8'h14, 8'h55};
        send_frame(0, 0);
        expect_idle("R7 locked program");
        check("R7 stays locked", locked0, 1'b1);
        sweep("R7", 1'b0);
        sweep("R7 init locked", 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule